// File: doc/BRIEF.md
# Mode-Switchable Windowed Lookahead Adder

This block adds two unsigned operands and a carry-in, then delivers the sum and the carry-out through an output register. Every internal carry is built from two terms. The near term looks back over only the `WINDOW` bit positions just below the carry. The far term covers all remaining lower positions, including the carry-in once it lies outside the window.

A mode input selects the behaviour for each operation. In exact mode, the two terms are ORed, and the result is a true binary sum. In approximate mode, only the near term reaches each carry multiplexer. The far-term logic also has its enable dropped, so that its output is held at zero. The result is then fast but may be wrong in the upper bits.

The mode can change on every cycle. This lets error-tolerant and exact operations be mixed freely in one operand stream.

Top module: `approx_cla_adder`

## Requirements
- R1: With `approx_en` = 0, the registered value {`carry_out_q`, `sum_q`} equals `op_a` + `op_b` + `carry_in` for every input combination. Per-bit propagate is a XOR b, and per-bit generate is a AND b.
- R2: With `approx_en` = 1, the carry into position k+1 equals the carry out of the sub-addition of operand bits max(0,k−WINDOW+1) through k. That sub-addition includes `carry_in` only when its lowest bit is position 0. `carry_out_q` is the carry into position WIDTH.
- R3: With `approx_en` = 1, `carry_in` has no effect on the carries into positions above WINDOW. Example (WIDTH 8, WINDOW 4): for a=FF, b=00, the result is sum E0 with carry-out 0 when cin=1, and sum FF with carry-out 0 when cin=0.
- R4: Sum bit i is the propagate bit i XOR the selected carry into position i. Carry 0 is `carry_in`.
- R5: Outputs appear exactly one clock edge after the operands, the carry-in and the mode are presented.
- R6: While `rst` is high, `sum_q` and `carry_out_q` are zero at the following clock edge.
- R7: In approximate mode, the far-term carries are all forced to zero, so the result depends only on the windowed terms.
- R8: In approximate mode, sum bits 0 through WINDOW are always exact.
- R9: The mode applies per operation, so alternating modes on consecutive cycles gives each result its own mode's value.
- R10: The default instance is 8 bits wide with a window of 4. Approximate mode at this size yields a nonzero number of inexact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| approx_en | input | 1 | 1 selects approximate mode, 0 selects exact mode |
| sum_q | output | WIDTH | Registered sum |
| carry_out_q | output | 1 | Registered carry-out |

## Verification
Exact mode is swept over every operand pair and both carry-in values at width 8. This separates a correct far term from any missing or misplaced lookahead product.

Approximate mode is swept over all values of the first operand, a strided set of the second, and both carry-in values. The results are compared against a model built from windowed sub-additions, which shows whether the window boundary sits at the right distance. The same sweep counts the inexact results and checks that the low WINDOW+1 bits stay exact.

Directed cases toggle the carry-in under a long propagate run to show that it does not reach past the window. Alternating modes on back-to-back cycles shows that the mode takes effect without delay.

// File: rtl/approx_cla_pkg.sv
package approx_cla_pkg;
  typedef enum logic {
    MODE_EXACT  = 1'b0,
    MODE_APPROX = 1'b1
  } add_mode_e;
endpackage

// File: rtl/acla_pg.sv
module acla_pg #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] gen
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign prop[i] = a[i] ^ b[i];
    assign gen[i]  = a[i] & b[i];
  end
endmodule

// File: rtl/acla_carry.sv
module acla_carry #(
  parameter int WIDTH  = 8,
  parameter int WINDOW = 4
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] gen,
  input  logic             cin,
  input  logic             far_en,
  output logic [WIDTH:1]   near_c,
  output logic [WIDTH:1]   far_c
);
  // One column per carry: split the lookahead products by distance.
  for (genvar k = 0; k < WIDTH; k++) begin : g_col
    logic col_near;
    logic col_far;
    always_comb begin
      logic run;
      col_near = 1'b0;
      col_far  = 1'b0;
      run      = 1'b1;
      for (int j = k; j >= 0; j--) begin
        if ((k - j) < WINDOW) col_near = col_near | (run & gen[j]);
        else                  col_far  = col_far  | (run & gen[j]);
        run = run & prop[j];
      end
      if (k < WINDOW) col_near = col_near | (run & cin);
      else            col_far  = col_far  | (run & cin);
    end
    assign near_c[k+1] = col_near;
    assign far_c[k+1]  = col_far & far_en;
  end
endmodule

// File: rtl/acla_select.sv
module acla_select #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH:1]   near_c,
  input  logic [WIDTH:1]   far_c,
  input  logic             cin,
  input  logic             use_near,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH:0] carry;
  assign carry[0] = cin;
  for (genvar k = 1; k <= WIDTH; k++) begin : g_mux
    assign carry[k] = use_near ? near_c[k] : (near_c[k] | far_c[k]);
  end
  assign sum  = prop ^ carry[WIDTH-1:0];
  assign cout = carry[WIDTH];
endmodule

// File: rtl/approx_cla_adder.sv
module approx_cla_adder #(
  parameter int WIDTH  = 8,
  parameter int WINDOW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic             approx_en,
  output logic [WIDTH-1:0] sum_q,
  output logic             carry_out_q
);
  import approx_cla_pkg::*;

  add_mode_e        mode;
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] gen;
  logic [WIDTH:1]   near_c;
  logic [WIDTH:1]   aug_c;
  logic             far_en;
  logic [WIDTH-1:0] sum_d;
  logic             cout_d;

  assign mode   = add_mode_e'(approx_en);
  assign far_en = (mode == MODE_EXACT);

  acla_pg #(.WIDTH(WIDTH)) u_pg (
    .a    (op_a),
    .b    (op_b),
    .prop (prop),
    .gen  (gen)
  );

  acla_carry #(.WIDTH(WIDTH), .WINDOW(WINDOW)) u_carry (
    .prop   (prop),
    .gen    (gen),
    .cin    (carry_in),
    .far_en (far_en),
    .near_c (near_c),
    .far_c  (aug_c)
  );

  acla_select #(.WIDTH(WIDTH)) u_sel (
    .prop     (prop),
    .near_c   (near_c),
    .far_c    (aug_c),
    .cin      (carry_in),
    .use_near (mode == MODE_APPROX),
    .sum      (sum_d),
    .cout     (cout_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q       <= '0;
      carry_out_q <= 1'b0;
    end else begin
      sum_q       <= sum_d;
      carry_out_q <= cout_d;
    end
  end
endmodule

// File: rtl/approx_cla_adder_chk.sv
module approx_cla_adder_chk #(
  parameter int WIDTH  = 8,
  parameter int WINDOW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic             approx_en,
  input logic [WIDTH-1:0] sum_q,
  input logic             carry_out_q,
  input logic [WIDTH:1]   aug_c
);
  localparam int LOWTOP = (WINDOW < WIDTH) ? WINDOW : WIDTH - 1;

  logic [WIDTH:0] exact_q;
  always_ff @(posedge clk) begin
    exact_q <= {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
  end

  // R6: reset clears the outputs
  assert_reset_clear_R6: assert property (@(posedge clk)
    $past(rst) |-> (sum_q == '0 && carry_out_q == 1'b0));

  // R1: exact mode gives the true sum one cycle later
  assert_exact_sum_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(approx_en)) |-> ({carry_out_q, sum_q} == exact_q));

  // R7: far carries held at zero in approximate mode
  assert_far_gated_R7: assert property (@(posedge clk) disable iff (rst)
    approx_en |-> (aug_c == '0));

  // R8: low bits stay exact in approximate mode
  assert_low_exact_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(approx_en)) |-> (sum_q[LOWTOP:0] == exact_q[LOWTOP:0]));
endmodule

bind approx_cla_adder approx_cla_adder_chk #(.WIDTH(WIDTH), .WINDOW(WINDOW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_a        (op_a),
  .op_b        (op_b),
  .carry_in    (carry_in),
  .approx_en   (approx_en),
  .sum_q       (sum_q),
  .carry_out_q (carry_out_q),
  .aug_c       (aug_c)
);

// File: tb/approx_cla_adder_tb.sv
module approx_cla_adder_tb;
  localparam int W   = 8;
  localparam int WIN = 4;

  typedef struct {
    logic [W:0] expv;
    logic [W:0] exactv;
    logic       approx;
    string      req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic         approx_en = 1'b0;
  logic [W-1:0] sum_q;
  logic         carry_out_q;

  int checks = 0;
  int errors = 0;
  int diff_seen = 0;
  int diff_model = 0;
  item_t q[$];

  always #5 clk = ~clk;

  approx_cla_adder #(.WIDTH(W), .WINDOW(WIN)) u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .approx_en(approx_en), .sum_q(sum_q), .carry_out_q(carry_out_q)
  );

  task automatic chk(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Windowed model: each carry comes from a sub-addition limited to the window.
  function automatic logic [W:0] approx_ref(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
    logic [W:0] c;
    int lo, n, aa, bb, s;
    c[0] = ci;
    for (int k = 0; k < W; k++) begin
      lo = (k - WIN + 1 < 0) ? 0 : k - WIN + 1;
      n  = k - lo + 1;
      aa = (int'(a) >> lo) & ((1 << n) - 1);
      bb = (int'(b) >> lo) & ((1 << n) - 1);
      s  = aa + bb + ((lo == 0) ? int'(ci) : 0);
      c[k+1] = ((s >> n) & 1) != 0;
    end
    return {c[W], (a ^ b) ^ c[W-1:0]};
  endfunction

  task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv, input logic ci,
                       input logic md, input string req);
    item_t it;
    @(negedge clk);
    op_a = av; op_b = bv; carry_in = ci; approx_en = md;
    it.exactv = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, ci};
    it.expv   = md ? approx_ref(av, bv, ci) : it.exactv;
    it.approx = md;
    it.req    = req;
    if (md && it.expv != it.exactv) diff_model++;
    q.push_back(it);
  endtask

  // Monitor: result registered at the edge after the drive (R5).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk({carry_out_q, sum_q} == it.expv, it.req, {carry_out_q, sum_q}, it.expv);
        if (it.approx) begin
          chk(sum_q[WIN:0] == it.exactv[WIN:0], "R8", {4'b0, sum_q[WIN:0]}, {4'b0, it.exactv[WIN:0]});
          if ({carry_out_q, sum_q} != it.exactv) diff_seen++;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin
    // R6: reset holds outputs at zero despite busy inputs
    op_a = 8'hFF; op_b = 8'hFF; carry_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({carry_out_q, sum_q} == '0, "R6", {carry_out_q, sum_q}, '0);
    rst = 1'b0;

    // R1: exhaustive exact mode (also R4, R5)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          drive(W'(a), W'(b), c[0], 1'b0, "R1");

    // R2, R7: approximate mode against windowed model
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 8)
        for (int c = 0; c < 2; c++)
          drive(W'(a), W'(b), c[0], 1'b1, "R2_R7");

    // R3: carry-in blocked beyond the window
    drive(8'hFF, 8'h00, 1'b1, 1'b1, "R3");
    drive(8'hFF, 8'h00, 1'b0, 1'b1, "R3");

    // R9: alternating modes back to back
    for (int i = 0; i < 8; i++) begin
      drive(8'h7F, 8'h01, 1'b0, i[0], "R9");
      drive(8'hF0, 8'h10, 1'b1, ~i[0], "R9");
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3 fixed values
    chk(approx_ref(8'hFF, 8'h00, 1'b1) == 9'h0E0, "R3", approx_ref(8'hFF, 8'h00, 1'b1), 9'h0E0);
    // R10: default instance shows inexact results, matching the model count
    chk(diff_seen > 0, "R10", 9'(diff_seen), 9'(1));
    chk(diff_seen == diff_model, "R10", 9'(diff_seen), 9'(diff_model));
    $display("approximate cases differing from exact: %0d", diff_seen);
    finish_run();
  end
endmodule